// File: doc/BRIEF.md
# Stepped Exposure and Gain Controller

This block keeps the working exposure setting and the output-stage gain setting of an image sensor. Exposure is a 16-bit value. The upper byte is the integration time in whole line periods. The lower byte is an extra count of pixel periods. Gain is an 8-bit value.

An external step clock adjusts both settings, and a direction input sets the sense of each step. The step clock may be asynchronous to the main clock. Each step changes exposure in proportion to its current value, and both fields are clamped to fixed limits. Once exposure reaches its ceiling, further increase steps raise the gain instead, but only in analogue mode. Decrease steps lower any gain first and only then lower exposure.

The sequencer reads the settings through a frame copy of both values. The frame copy is captured when the frame-start pulse rises, so a change takes effect from the next frame. The frame copy also feeds the frame header. Steps that arrive while the frame-start pulse is high are dropped.

A two-state machine tracks the frame-start pulse:
- In `FS_OPEN`, the transition *capture* to `FS_HOLD` fires on the first cycle with `frame_start` high. On that edge the frame copy is loaded.
- In `FS_HOLD`, the transition *release* back to `FS_OPEN` fires on the first cycle with `frame_start` low.

Top module: `expgain_ctrl`

## Requirements
- R1: While `rst_n` is low, all registers reset asynchronously. Exposure then reads 0xA2A7 (line field 162, pixel field 167), gain reads 0, and the frame copies hold the same values.
- R2: The line field (`exp_cur[15:8]`) always stays within 0..162. The pixel field (`exp_cur[7:0]`) always stays within 16..167.
- R3: Whenever the line field is above 8, the pixel field equals 167.
- R4: A step with a line field of 8 or less works on the whole value. It adds or subtracts d = max(exp_cur>>4, 1) to the pixel field. If the pixel field passes 167 it carries: the line field goes up by 1 and the pixel field drops by 152. If the pixel field falls below 16 it borrows: the line field goes down by 1 and the pixel field rises by 152. A borrow at line field 0 clamps the pixel field to 16 instead. With a line field above 8, a step adds or subtracts max(line>>4, 1) to the line field, which is clamped at 162.
- R5: Exposure saturates at both ends. An increase step at 0xA2A7 in digital mode changes nothing. A decrease step at 0x0010 with gain 0 changes nothing.
- R6: In analogue mode (`analog_mode`=1), an increase step at 0xA2A7 raises gain by 1, up to 247. Further increase steps are ignored.
- R7: A decrease step while gain is non-zero lowers gain by 1 and leaves exposure unchanged.
- R8: On the first cycle of a `frame_start` pulse, `exp_frame` and `gain_frame` load `exp_cur` and `gain_cur`. They hold their values at all other times.
- R9: A step whose synchronised rising edge arrives while `frame_start` is high has no effect.
- R10: Each rising edge of `step_clk` applies exactly one step, with the direction taken from `step_up` (1 = increase). The result appears on `exp_cur` and `gain_cur` by the third main-clock edge after the rising edge. Each high phase and each low phase of `step_clk` must last at least two main-clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_clk | input | 1 | Asynchronous step clock; one step per rising edge |
| step_up | input | 1 | Step direction: 1 increase, 0 decrease |
| analog_mode | input | 1 | 1 allows gain steps once exposure is at its ceiling |
| frame_start | input | 1 | Frame-start pulse, synchronous to `clk` |
| exp_cur | output | 16 | Working exposure value {lines, pixels} |
| gain_cur | output | 8 | Working gain value |
| exp_frame | output | 16 | Exposure copy captured at frame start |
| gain_frame | output | 8 | Gain copy captured at frame start |

## Verification
The bench checks the carry and borrow between the two fields, which a wrong design would get stuck on or corrupt. It also checks the switch from whole-value steps to line-field steps when the line field crosses 8. It drives exposure into both saturation points, where a faulty design would wrap the value or let a digital-mode increase leak into gain. It checks gain saturation at 247 and the rule that a decrease step lowers gain before exposure. It checks that a step arriving during the frame-start pulse is dropped, which a careless design would apply or latch early.

// File: rtl/expgain_pkg.sv
package expgain_pkg;

    // Frame-start tracking states
    typedef enum logic {
        FS_OPEN = 1'b0,   // outside the frame-start pulse
        FS_HOLD = 1'b1    // inside the frame-start pulse, copy already taken
    } frame_state_e;

endpackage

// File: rtl/expgain_sync.sv
// Brings the step clock and direction into the main clock domain and
// produces a one-cycle pulse per rising edge of the step clock.
module expgain_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_clk,
    input  logic step_up,
    output logic step_pulse,
    output logic step_dir
);
    logic [STAGES-1:0] clk_sh;
    logic [STAGES-1:0] dir_sh;
    logic              clk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sh   <= '0;
            dir_sh   <= '0;
            clk_prev <= 1'b0;
        end else begin
            clk_sh   <= {clk_sh[STAGES-2:0], step_clk};
            dir_sh   <= {dir_sh[STAGES-2:0], step_up};
            clk_prev <= clk_sh[STAGES-1];
        end
    end

    assign step_pulse = clk_sh[STAGES-1] & ~clk_prev;
    assign step_dir   = dir_sh[STAGES-1];
endmodule

// File: rtl/expgain_step.sv
// Next-value arithmetic for one step: proportional exposure change with
// field carry/borrow, clamping, and hand-over to gain at the ceiling.
module expgain_step #(
    parameter int FW       = 8,
    parameter int GW       = 8,
    parameter int HI_MAX   = 162,
    parameter int HI_LINK  = 8,
    parameter int LO_MIN   = 16,
    parameter int LO_MAX   = 167,
    parameter int GAIN_MAX = 247,
    parameter int SHIFT    = 4
) (
    input  logic [2*FW-1:0] exp_in,
    input  logic [GW-1:0]   gain_in,
    input  logic            up,
    input  logic            analog,
    output logic [2*FW-1:0] exp_out,
    output logic [GW-1:0]   gain_out
);
    localparam int EW      = 2 * FW;
    localparam int LO_SPAN = LO_MAX - LO_MIN + 1;

    int   h, l, dl, dh, h_n, l_n;
    logic at_max;

    always_comb begin
        h   = int'(exp_in[EW-1:FW]);
        l   = int'(exp_in[FW-1:0]);
        dl  = int'(exp_in >> SHIFT);
        if (dl < 1) dl = 1;
        dh  = h / (1 << SHIFT);
        if (dh < 1) dh = 1;
        h_n = h;
        l_n = l;
        gain_out = gain_in;
        at_max = (h == HI_MAX) && (l == LO_MAX);

        if (up) begin
            if (at_max) begin
                if (analog && (int'(gain_in) < GAIN_MAX))
                    gain_out = gain_in + GW'(1);
            end else if (h > HI_LINK) begin
                h_n = h + dh;
                if (h_n > HI_MAX) h_n = HI_MAX;
                l_n = LO_MAX;
            end else begin
                l_n = l + dl;
                if (l_n > LO_MAX) begin
                    l_n = l_n - LO_SPAN;
                    h_n = h + 1;
                end
                if (h_n > HI_LINK) l_n = LO_MAX;
            end
        end else begin
            if (gain_in != '0) begin
                gain_out = gain_in - GW'(1);
            end else if (h > HI_LINK) begin
                h_n = h - dh;
                l_n = LO_MAX;
            end else begin
                l_n = l - dl;
                if (l_n < LO_MIN) begin
                    if (h == 0) begin
                        l_n = LO_MIN;
                    end else begin
                        h_n = h - 1;
                        l_n = l_n + LO_SPAN;
                    end
                end
            end
        end

        exp_out = {FW'(h_n), FW'(l_n)};
    end
endmodule

// File: rtl/expgain_ctrl.sv
module expgain_ctrl
    import expgain_pkg::*;
#(
    parameter int FW          = 8,
    parameter int GW          = 8,
    parameter int HI_MAX      = 162,
    parameter int HI_LINK     = 8,
    parameter int LO_MIN      = 16,
    parameter int LO_MAX      = 167,
    parameter int GAIN_MAX    = 247,
    parameter int SHIFT       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_clk,
    input  logic            step_up,
    input  logic            analog_mode,
    input  logic            frame_start,
    output logic [2*FW-1:0] exp_cur,
    output logic [GW-1:0]   gain_cur,
    output logic [2*FW-1:0] exp_frame,
    output logic [GW-1:0]   gain_frame
);
    localparam int              EW      = 2 * FW;
    localparam logic [EW-1:0]   EXP_TOP = {FW'(HI_MAX), FW'(LO_MAX)};

    frame_state_e    state, state_n;
    logic            step_pulse, step_dir;
    logic            take_step, latch_en;
    logic [EW-1:0]   exp_nx;
    logic [GW-1:0]   gain_nx;

    expgain_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_clk   (step_clk),
        .step_up    (step_up),
        .step_pulse (step_pulse),
        .step_dir   (step_dir)
    );

    expgain_step #(
        .FW(FW), .GW(GW), .HI_MAX(HI_MAX), .HI_LINK(HI_LINK),
        .LO_MIN(LO_MIN), .LO_MAX(LO_MAX), .GAIN_MAX(GAIN_MAX), .SHIFT(SHIFT)
    ) u_step (
        .exp_in   (exp_cur),
        .gain_in  (gain_cur),
        .up       (step_dir),
        .analog   (analog_mode),
        .exp_out  (exp_nx),
        .gain_out (gain_nx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_OPEN;
        else        state <= state_n;
    end

    // Transitions: capture (OPEN->HOLD), release (HOLD->OPEN)
    always_comb begin
        state_n = state;
        unique case (state)
            FS_OPEN: if (frame_start)  state_n = FS_HOLD;
            FS_HOLD: if (!frame_start) state_n = FS_OPEN;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        latch_en  = (state == FS_OPEN) && frame_start;
        take_step = step_pulse && !frame_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_cur    <= EXP_TOP;
            gain_cur   <= '0;
            exp_frame  <= EXP_TOP;
            gain_frame <= '0;
        end else begin
            if (take_step) begin
                exp_cur  <= exp_nx;
                gain_cur <= gain_nx;
            end
            if (latch_en) begin
                exp_frame  <= exp_cur;
                gain_frame <= gain_cur;
            end
        end
    end
endmodule

// File: rtl/expgain_ctrl_chk.sv
module expgain_ctrl_chk #(
    parameter int FW       = 8,
    parameter int GW       = 8,
    parameter int HI_MAX   = 162,
    parameter int HI_LINK  = 8,
    parameter int LO_MIN   = 16,
    parameter int LO_MAX   = 167,
    parameter int GAIN_MAX = 247
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_start,
    input logic [2*FW-1:0] exp_cur,
    input logic [GW-1:0]   gain_cur,
    input logic [2*FW-1:0] exp_frame,
    input logic [GW-1:0]   gain_frame
);
    localparam logic [2*FW-1:0] EXP_TOP = {FW'(HI_MAX), FW'(LO_MAX)};

    p_field_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(exp_cur[2*FW-1:FW]) <= HI_MAX &&
        int'(exp_cur[FW-1:0]) >= LO_MIN && int'(exp_cur[FW-1:0]) <= LO_MAX);

    p_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(exp_cur[2*FW-1:FW]) > HI_LINK |-> int'(exp_cur[FW-1:0]) == LO_MAX);

    p_gain_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(gain_cur) <= GAIN_MAX);

    p_gain_at_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gain_cur > $past(gain_cur) |-> exp_cur == EXP_TOP);

    p_gain_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exp_cur != $past(exp_cur) |-> $past(gain_cur) == '0 || gain_cur != '0);

    p_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_start) |=> exp_frame == $past(exp_cur) && gain_frame == $past(gain_cur));

    p_hold_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(exp_frame) && $stable(gain_frame));

    p_drop_in_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> $stable(exp_cur) && $stable(gain_cur));
endmodule

bind expgain_ctrl expgain_ctrl_chk #(
    .FW(FW), .GW(GW), .HI_MAX(HI_MAX), .HI_LINK(HI_LINK),
    .LO_MIN(LO_MIN), .LO_MAX(LO_MAX), .GAIN_MAX(GAIN_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .exp_cur     (exp_cur),
    .gain_cur    (gain_cur),
    .exp_frame   (exp_frame),
    .gain_frame  (gain_frame)
);

// File: tb/expgain_ctrl_tb.sv
module expgain_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_clk = 1'b0;
    logic        step_up = 1'b0;
    logic        analog_mode = 1'b0;
    logic        frame_start = 1'b0;
    logic [15:0] exp_cur, exp_frame;
    logic [7:0]  gain_cur, gain_frame;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int m_exp;
    int m_gain;

    always #2 clk = ~clk;

    expgain_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .step_clk(step_clk), .step_up(step_up),
        .analog_mode(analog_mode), .frame_start(frame_start),
        .exp_cur(exp_cur), .gain_cur(gain_cur),
        .exp_frame(exp_frame), .gain_frame(gain_frame)
    );

    // Reference step rules taken from R4..R7
    function automatic void model_step(input bit up, input bit ana);
        int hi, lo, d;
        hi = m_exp / 256;
        lo = m_exp % 256;
        if (up) begin
            if (m_exp == 16'hA2A7) begin
                if (ana && m_gain < 247) m_gain++;
                return;
            end
            if (hi > 8) begin
                d = (hi >> 4) < 1 ? 1 : (hi >> 4);
                hi = (hi + d > 162) ? 162 : hi + d;
                lo = 167;
            end else begin
                d = (m_exp >> 4) < 1 ? 1 : (m_exp >> 4);
                lo += d;
                if (lo > 167) begin lo -= 152; hi++; end
                if (hi > 8) lo = 167;
            end
        end else begin
            if (m_gain > 0) begin m_gain--; return; end
            if (hi > 8) begin
                d = (hi >> 4) < 1 ? 1 : (hi >> 4);
                hi -= d;
                lo = 167;
            end else begin
                d = (m_exp >> 4) < 1 ? 1 : (m_exp >> 4);
                lo -= d;
                if (lo < 16) begin
                    if (hi == 0) lo = 16;
                    else begin hi--; lo += 152; end
                end
            end
        end
        m_exp = hi * 256 + lo;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // One step pulse: high and low phases of three clocks each
    task automatic pulse(input bit up);
        @(negedge clk) step_up = up;
        @(negedge clk) step_clk = 1'b1;
        repeat (3) @(negedge clk);
        step_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic step_chk(input bit up, input string req);
        pulse(up);
        if (!frame_start) model_step(up, analog_mode);
        chk(req, int'(exp_cur), m_exp);
        chk(req, int'(gain_cur), m_gain);
    endtask

    task automatic frame_chk(input string req);
        @(negedge clk) frame_start = 1'b1;
        repeat (2) @(negedge clk);
        chk(req, int'(exp_frame), m_exp);
        chk(req, int'(gain_frame), m_gain);
        frame_start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5E));
        m_exp = 16'hA2A7;
        m_gain = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", int'(exp_cur), 16'hA2A7);
        chk("R1", int'(gain_cur), 0);
        chk("R1", int'(exp_frame), 16'hA2A7);
        chk("R1", int'(gain_frame), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5: increase at ceiling in digital mode does nothing
        step_chk(1'b1, "R5");
        chk("R5", int'(exp_cur), 16'hA2A7);
        // R4: line-field step down from ceiling: 162-10 = 152
        step_chk(1'b0, "R4");
        chk("R4", int'(exp_cur), 16'h98A7);
        while (m_exp != 16'hA2A7) step_chk(1'b1, "R4");

        // R6: gain rises at ceiling in analogue mode
        analog_mode = 1'b1;
        repeat (3) step_chk(1'b1, "R6");
        chk("R6", int'(gain_cur), 3);
        // R7: decrease lowers gain first
        step_chk(1'b0, "R7");
        chk("R7", int'(gain_cur), 2);
        chk("R7", int'(exp_cur), 16'hA2A7);

        // R8: frame copy; R9: step inside frame-start pulse dropped
        frame_chk("R8");
        @(negedge clk) frame_start = 1'b1;
        pulse(1'b1);
        chk("R9", int'(exp_cur), m_exp);
        chk("R9", int'(gain_cur), m_gain);
        frame_start = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9", int'(gain_cur), m_gain);

        // R6: gain saturates at 247
        repeat (250) step_chk(1'b1, "R6");
        chk("R6", int'(gain_cur), 247);
        // R7: gain drained before exposure moves
        repeat (247) step_chk(1'b0, "R7");
        chk("R7", int'(exp_cur), 16'hA2A7);
        chk("R7", int'(gain_cur), 0);

        // R4/R5: walk to the floor through borrows
        repeat (200) step_chk(1'b0, "R4");
        chk("R5", int'(exp_cur), 16'h0010);
        step_chk(1'b0, "R5");
        chk("R5", int'(exp_cur), 16'h0010);
        // R4: carries on the way back up
        repeat (40) step_chk(1'b1, "R4");

        // R2/R3/R10: random steps and modes
        for (int i = 0; i < 400; i++) begin
            analog_mode = ($urandom % 4) == 0;
            step_chk(($urandom % 8) < 5, "R10");
            checks++;
            if ((exp_cur[15:8] > 8'd162) || (exp_cur[7:0] < 8'd16) || (exp_cur[7:0] > 8'd167)
                || (exp_cur[15:8] > 8'd8 && exp_cur[7:0] != 8'd167)) begin
                errors++;
                $display("FAIL R2/R3: got 0x%0h expected fields in range", exp_cur);
            end
            if (i % 37 == 0) frame_chk("R8");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule